// File: doc/BRIEF.md
# CPU Reset and Interrupt Poll Unit

This block sits beside an 8-bit accumulator-style processor core. It supplies the register values that the core starts from after a reset, and it decides at each instruction boundary whether an interrupt is to be taken. There are two kinds of reset. A cold reset forces the accumulator, both index registers, the stack pointer and the status byte to fixed constants. A warm reset starts from the core's live register values, moves the stack pointer down by three and sets interrupt-disable. After either kind, the block fetches the 16-bit start address through a valid/ready read port. It reads the low byte first and then the high byte.

Interrupt polling is pipelined. On every qualifying cycle the block samples a raw request, which is a pending NMI, or a nonzero IRQ source count while interrupts are enabled. That sample then passes through a second register. When the core marks the end of an instruction, the block uses the value in this second register, so the line state one cycle earlier than the last cycle is the one that counts. A cycle qualifies only when the cycle strobe is high and neither DMA engine is stalling the core. During a stall both registers hold their values.

Top module: `cpu_rst_poll`

## Requirements
- R1: A cold reset pulse sets a_o, x_o and y_o to 0x00, sp_o to 0xFD and ps_o to 0x24 (bit 5 reserved, bit 2 interrupt-disable) at the next edge.
- R2: A warm reset pulse without a cold reset loads a_o, x_o and y_o from cur_a, cur_x and cur_y. It loads sp_o with cur_sp minus 3 (modulo 256) and ps_o with cur_ps with bit 2 set.
- R3: After either reset the read port presents address 0xFFFC and then 0xFFFD. vec_valid and vec_addr stay steady while vec_ready is low. A byte is taken on each cycle where vec_valid and vec_ready are both high. One edge after the second handshake, pc_o equals {high byte, low byte}, init_done is high for one cycle and vec_valid is low.
- R4: clr_pend is high for exactly one cycle, the cycle after any reset pulse, so that the core clears its NMI pending flag and IRQ count.
- R5: The raw request is nmi_pend OR (irq_cnt nonzero AND cur_ps bit 2 clear).
- R6: The raw request is registered on a qualifying edge. The registered value moves into a delayed register on the next qualifying edge, and only the delayed value is used at instruction end.
- R7: An edge is not qualifying when cyc_strobe is low, spr_dma is high or dmc_dma is high. On such an edge neither request register changes.
- R8: A cold reset clears both request registers and take_int. A warm reset leaves the request registers unchanged.
- R9: take_int is a one-cycle pulse. It is high in the cycle after an edge where instr_end was high and the delayed request was set.
- R10: Cold reset takes priority over a simultaneous warm reset. A reset pulse during a vector fetch restarts the fetch at the low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low register reset (cold values, PC 0) |
| cold_rst | input | 1 | Cold reset pulse |
| warm_rst | input | 1 | Warm reset pulse |
| cur_a | input | 8 | Core's live accumulator |
| cur_x | input | 8 | Core's live X index |
| cur_y | input | 8 | Core's live Y index |
| cur_sp | input | 8 | Core's live stack pointer |
| cur_ps | input | 8 | Core's live status byte; bit 2 is interrupt-disable |
| vec_valid | output | 1 | Vector read request valid |
| vec_ready | input | 1 | Memory accepts the read; vec_data is valid in the same cycle |
| vec_addr | output | 16 | Vector read address |
| vec_data | input | 8 | Vector read data |
| nmi_pend | input | 1 | NMI pending flag |
| irq_cnt | input | 4 | Number of active IRQ sources |
| cyc_strobe | input | 1 | One core cycle elapsed |
| spr_dma | input | 1 | Sprite DMA stalling the core |
| dmc_dma | input | 1 | Sample DMA stalling the core |
| instr_end | input | 1 | Pulse on the last cycle of an instruction |
| a_o | output | 8 | Start accumulator |
| x_o | output | 8 | Start X |
| y_o | output | 8 | Start Y |
| sp_o | output | 8 | Start stack pointer |
| ps_o | output | 8 | Start status byte |
| pc_o | output | 16 | Start program counter |
| init_done | output | 1 | Vector fetch complete, one cycle |
| clr_pend | output | 1 | Clear pending interrupt state, one cycle |
| take_int | output | 1 | Take interrupt after this instruction |

## Verification
Register values and clr_pend are due one edge after the reset pulse. The first vector address is due at that same edge, and pc_o and init_done are due one edge after the second handshake. A raw request shows up in take_int only after two qualifying edges, and then one edge after the instr_end cycle. The bench applies every input one time unit after a rising edge. It samples one time unit after the edge at which each result is due, so it can check that take_int is still low one edge early. Stall cases hold DMA or drop the strobe across several edges, then count the qualifying edges after release before they expect the pulse.

// File: rtl/cpu_rst_pkg.sv
package cpu_rst_pkg;
  typedef enum logic [1:0] {
    FETCH_IDLE = 2'd0,
    FETCH_LO   = 2'd1,
    FETCH_HI   = 2'd2
  } fetch_st_e;

  localparam int PS_RSV_BIT  = 5;
  localparam int PS_IDIS_BIT = 2;
endpackage

// File: rtl/rst_vec_fetch.sv
module rst_vec_fetch
  import cpu_rst_pkg::*;
#(
  parameter int          AW  = 16,
  parameter int          DW  = 8,
  parameter logic [15:0] VEC = 16'hFFFC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          rd_ready,
  input  logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic [AW-1:0] rd_addr,
  output logic [2*DW-1:0] pc,
  output logic          done
);
  localparam logic [AW-1:0] VEC_LO = AW'(VEC);
  localparam logic [AW-1:0] VEC_HI = AW'(VEC) + AW'(1);

  fetch_st_e     st_q;
  logic [DW-1:0] lo_q;

  assign rd_valid = (st_q != FETCH_IDLE);
  assign rd_addr  = (st_q == FETCH_HI) ? VEC_HI : VEC_LO;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= FETCH_IDLE;
      lo_q <= '0;
      pc   <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        st_q <= FETCH_LO;
      end else begin
        case (st_q)
          FETCH_LO: if (rd_ready) begin
            lo_q <= rd_data;
            st_q <= FETCH_HI;
          end
          FETCH_HI: if (rd_ready) begin
            pc   <= {rd_data, lo_q};
            done <= 1'b1;
            st_q <= FETCH_IDLE;
          end
          default: st_q <= FETCH_IDLE;
        endcase
      end
    end
  end

  a_r3_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !start) |=> (rd_valid && $stable(rd_addr)));
  a_r3_done_after_hi: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(rd_valid && rd_ready && !start) && $past(rd_addr) == VEC_HI && !rd_valid));
  a_r10_restart_lo: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (rd_valid && rd_addr == VEC_LO));
endmodule

// File: rtl/rst_regfile.sv
module rst_regfile
  import cpu_rst_pkg::*;
#(
  parameter int          DW          = 8,
  parameter logic [7:0]  SP_COLD     = 8'hFD,
  parameter int          SP_WARM_DEC = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cold,
  input  logic          warm,
  input  logic [DW-1:0] cur_a,
  input  logic [DW-1:0] cur_x,
  input  logic [DW-1:0] cur_y,
  input  logic [DW-1:0] cur_sp,
  input  logic [DW-1:0] cur_ps,
  output logic [DW-1:0] a,
  output logic [DW-1:0] x,
  output logic [DW-1:0] y,
  output logic [DW-1:0] sp,
  output logic [DW-1:0] ps,
  output logic          clr_pend
);
  localparam logic [DW-1:0] PS_COLD  = DW'((1 << PS_RSV_BIT) | (1 << PS_IDIS_BIT));
  localparam logic [DW-1:0] IDIS_MSK = DW'(1 << PS_IDIS_BIT);
  localparam logic [DW-1:0] SP_INIT  = DW'(SP_COLD);
  localparam logic [DW-1:0] SP_DEC   = DW'(SP_WARM_DEC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a <= '0; x <= '0; y <= '0;
      sp <= SP_INIT;
      ps <= PS_COLD;
      clr_pend <= 1'b0;
    end else begin
      clr_pend <= cold | warm;
      if (cold) begin
        a <= '0; x <= '0; y <= '0;
        sp <= SP_INIT;
        ps <= PS_COLD;
      end else if (warm) begin
        a  <= cur_a;
        x  <= cur_x;
        y  <= cur_y;
        sp <= cur_sp - SP_DEC;
        ps <= cur_ps | IDIS_MSK;
      end
    end
  end

  a_r1_cold_vals: assert property (@(posedge clk) disable iff (!rst_n)
    cold |=> (a == '0 && x == '0 && y == '0 && sp == SP_INIT && ps == PS_COLD));
  a_r2_warm_vals: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && !cold) |=> (sp == $past(cur_sp) - SP_DEC && a == $past(cur_a) && ps[PS_IDIS_BIT]));
  a_r4_clr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (!cold && !warm) |=> !clr_pend);
endmodule

// File: rtl/int_poll.sv
module int_poll
  import cpu_rst_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cold,
  input  logic             nmi,
  input  logic [CNT_W-1:0] irq_cnt,
  input  logic             idis,
  input  logic             strobe,
  input  logic             spr_dma,
  input  logic             dmc_dma,
  input  logic             instr_end,
  output logic             take
);
  logic raw, adv, req_q, req_d;

  assign raw = nmi | ((irq_cnt != '0) & ~idis);
  assign adv = strobe & ~spr_dma & ~dmc_dma;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      req_d <= 1'b0;
      take  <= 1'b0;
    end else if (cold) begin
      req_q <= 1'b0;
      req_d <= 1'b0;
      take  <= 1'b0;
    end else begin
      take <= instr_end & req_d;
      if (adv) begin
        req_q <= raw;
        req_d <= req_q;
      end
    end
  end

  a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!cold && (!strobe || spr_dma || dmc_dma)) |=> ($stable(req_q) && $stable(req_d)));
  a_r6_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (!cold && strobe && !spr_dma && !dmc_dma) |=> (req_d == $past(req_q)));
  a_r5_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (!cold && strobe && !spr_dma && !dmc_dma && nmi) |=> req_q);
  a_r8_cold_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cold |=> (!req_q && !req_d && !take));
  a_r9_take_cause: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> $past(instr_end));
endmodule

// File: rtl/cpu_rst_poll.sv
module cpu_rst_poll
  import cpu_rst_pkg::*;
#(
  parameter int          DATA_W      = 8,
  parameter int          ADDR_W      = 16,
  parameter int          IRQ_CNT_W   = 4,
  parameter logic [15:0] RST_VEC     = 16'hFFFC,
  parameter logic [7:0]  SP_COLD     = 8'hFD,
  parameter int          SP_WARM_DEC = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cold_rst,
  input  logic                 warm_rst,
  input  logic [DATA_W-1:0]    cur_a,
  input  logic [DATA_W-1:0]    cur_x,
  input  logic [DATA_W-1:0]    cur_y,
  input  logic [DATA_W-1:0]    cur_sp,
  input  logic [DATA_W-1:0]    cur_ps,
  output logic                 vec_valid,
  input  logic                 vec_ready,
  output logic [ADDR_W-1:0]    vec_addr,
  input  logic [DATA_W-1:0]    vec_data,
  input  logic                 nmi_pend,
  input  logic [IRQ_CNT_W-1:0] irq_cnt,
  input  logic                 cyc_strobe,
  input  logic                 spr_dma,
  input  logic                 dmc_dma,
  input  logic                 instr_end,
  output logic [DATA_W-1:0]    a_o,
  output logic [DATA_W-1:0]    x_o,
  output logic [DATA_W-1:0]    y_o,
  output logic [DATA_W-1:0]    sp_o,
  output logic [DATA_W-1:0]    ps_o,
  output logic [2*DATA_W-1:0]  pc_o,
  output logic                 init_done,
  output logic                 clr_pend,
  output logic                 take_int
);
  logic any_rst;
  assign any_rst = cold_rst | warm_rst;

  rst_regfile #(.DW(DATA_W), .SP_COLD(SP_COLD), .SP_WARM_DEC(SP_WARM_DEC)) u_regs (
    .clk(clk), .rst_n(rst_n), .cold(cold_rst), .warm(warm_rst),
    .cur_a(cur_a), .cur_x(cur_x), .cur_y(cur_y), .cur_sp(cur_sp), .cur_ps(cur_ps),
    .a(a_o), .x(x_o), .y(y_o), .sp(sp_o), .ps(ps_o), .clr_pend(clr_pend)
  );

  rst_vec_fetch #(.AW(ADDR_W), .DW(DATA_W), .VEC(RST_VEC)) u_fetch (
    .clk(clk), .rst_n(rst_n), .start(any_rst),
    .rd_ready(vec_ready), .rd_data(vec_data),
    .rd_valid(vec_valid), .rd_addr(vec_addr),
    .pc(pc_o), .done(init_done)
  );

  int_poll #(.CNT_W(IRQ_CNT_W)) u_poll (
    .clk(clk), .rst_n(rst_n), .cold(cold_rst),
    .nmi(nmi_pend), .irq_cnt(irq_cnt), .idis(cur_ps[PS_IDIS_BIT]),
    .strobe(cyc_strobe), .spr_dma(spr_dma), .dmc_dma(dmc_dma),
    .instr_end(instr_end), .take(take_int)
  );

  a_r9_take_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (take_int && !instr_end) |=> !take_int);
endmodule

// File: tb/sim_cpu_rst_poll.sv
module sim_cpu_rst_poll;
  logic clk = 1'b0;
  logic rst_n;
  logic cold_rst, warm_rst;
  logic [7:0] cur_a, cur_x, cur_y, cur_sp, cur_ps;
  logic vec_valid, vec_ready;
  logic [15:0] vec_addr;
  logic [7:0] vec_data;
  logic nmi_pend;
  logic [3:0] irq_cnt;
  logic cyc_strobe, spr_dma, dmc_dma, instr_end;
  logic [7:0] a_o, x_o, y_o, sp_o, ps_o;
  logic [15:0] pc_o;
  logic init_done, clr_pend, take_int;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  cpu_rst_poll u0 (
    .clk(clk), .rst_n(rst_n), .cold_rst(cold_rst), .warm_rst(warm_rst),
    .cur_a(cur_a), .cur_x(cur_x), .cur_y(cur_y), .cur_sp(cur_sp), .cur_ps(cur_ps),
    .vec_valid(vec_valid), .vec_ready(vec_ready), .vec_addr(vec_addr), .vec_data(vec_data),
    .nmi_pend(nmi_pend), .irq_cnt(irq_cnt), .cyc_strobe(cyc_strobe),
    .spr_dma(spr_dma), .dmc_dma(dmc_dma), .instr_end(instr_end),
    .a_o(a_o), .x_o(x_o), .y_o(y_o), .sp_o(sp_o), .ps_o(ps_o), .pc_o(pc_o),
    .init_done(init_done), .clr_pend(clr_pend), .take_int(take_int)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic idle_inputs();
    cold_rst = 0; warm_rst = 0; vec_ready = 0; vec_data = 0;
    nmi_pend = 0; irq_cnt = 0; cyc_strobe = 0; spr_dma = 0; dmc_dma = 0; instr_end = 0;
  endtask

  // Finish a fetch already started: two ready handshakes.
  task automatic finish_fetch(input logic [7:0] lo, input logic [7:0] hi);
    vec_ready = 1; vec_data = lo; tick();
    vec_data = hi; tick();
    vec_ready = 0;
  endtask

  task automatic t_cold_fetch();
    cold_rst = 1; tick(); cold_rst = 0;
    chk("R1 a", a_o, 8'h00); chk("R1 sp", sp_o, 8'hFD); chk("R1 ps", ps_o, 8'h24);
    chk("R4 clr_pend", clr_pend, 1);
    chk("R3 valid", vec_valid, 1); chk("R3 addr lo", vec_addr, 16'hFFFC);
    tick();
    chk("R4 clr_pend single", clr_pend, 0);
    chk("R3 backpressure addr", vec_addr, 16'hFFFC); chk("R3 backpressure valid", vec_valid, 1);
    vec_ready = 1; vec_data = 8'h34; tick();
    chk("R3 addr hi", vec_addr, 16'hFFFD);
    vec_data = 8'h12; tick(); vec_ready = 0;
    chk("R3 pc", pc_o, 16'h1234); chk("R3 done", init_done, 1); chk("R3 valid low", vec_valid, 0);
    tick();
    chk("R3 done single", init_done, 0);
  endtask

  task automatic t_warm();
    cur_a = 8'h5A; cur_x = 8'hC3; cur_y = 8'h7E; cur_sp = 8'h01; cur_ps = 8'h81;
    warm_rst = 1; tick(); warm_rst = 0;
    chk("R2 a", a_o, 8'h5A); chk("R2 x", x_o, 8'hC3); chk("R2 y", y_o, 8'h7E);
    chk("R2 sp wrap", sp_o, 8'hFE); chk("R2 ps", ps_o, 8'h85); chk("R4 clr warm", clr_pend, 1);
    finish_fetch(8'hCD, 8'hAB);
    chk("R3 warm pc", pc_o, 16'hABCD);
    cur_ps = 8'h20;
  endtask

  task automatic t_priority_restart();
    cur_sp = 8'h40;
    cold_rst = 1; warm_rst = 1; tick(); cold_rst = 0; warm_rst = 0;
    chk("R10 cold wins sp", sp_o, 8'hFD);
    vec_ready = 1; vec_data = 8'h11; tick(); vec_ready = 0;
    chk("R10 at hi", vec_addr, 16'hFFFD);
    warm_rst = 1; tick(); warm_rst = 0;
    chk("R10 restart lo", vec_addr, 16'hFFFC);
    finish_fetch(8'h22, 8'h33);
    chk("R10 restarted pc", pc_o, 16'h3322);
  endtask

  task automatic t_nmi_pipe();
    cur_ps = 8'h24; cyc_strobe = 1;
    nmi_pend = 1; tick();
    chk("R6 take early", take_int, 0);
    nmi_pend = 0; instr_end = 1; tick();
    chk("R6 not yet", take_int, 0);
    tick();
    chk("R5 R9 nmi taken", take_int, 1);
    tick();
    chk("R9 single pulse", take_int, 0);
    instr_end = 0; cyc_strobe = 0;
  endtask

  task automatic t_irq_mask();
    cyc_strobe = 1; instr_end = 1; irq_cnt = 4'd2; cur_ps = 8'h24;
    tick(); tick(); tick();
    chk("R5 masked irq", take_int, 0);
    cur_ps = 8'h20; tick(); tick();
    chk("R6 irq two edges", take_int, 0);
    tick();
    chk("R5 unmasked irq", take_int, 1);
    irq_cnt = 0; tick(); tick(); tick();
    chk("R5 drained", take_int, 0);
    instr_end = 0; cyc_strobe = 0; cur_ps = 8'h24;
  endtask

  // mode 0: sprite DMA, 1: sample DMA, 2: strobe low
  task automatic t_stall(input int mode, input string tag);
    cyc_strobe = 1; nmi_pend = 1; tick();
    nmi_pend = 0; instr_end = 1;
    if (mode == 0) spr_dma = 1;
    else if (mode == 1) dmc_dma = 1;
    else cyc_strobe = 0;
    tick(); tick(); tick();
    chk({tag, " frozen"}, take_int, 0);
    spr_dma = 0; dmc_dma = 0; cyc_strobe = 1;
    tick();
    chk({tag, " first edge"}, take_int, 0);
    tick();
    chk({tag, " released"}, take_int, 1);
    instr_end = 0; tick(); tick(); cyc_strobe = 0;
  endtask

  task automatic t_reset_pipe(input logic cold);
    cyc_strobe = 1; nmi_pend = 1; tick(); tick();
    nmi_pend = 0; cyc_strobe = 0;
    if (cold) cold_rst = 1; else warm_rst = 1;
    tick(); cold_rst = 0; warm_rst = 0;
    finish_fetch(8'h00, 8'h80);
    cyc_strobe = 1; instr_end = 1; tick();
    if (cold) chk("R8 cold clears", take_int, 0);
    else      chk("R8 warm keeps", take_int, 1);
    instr_end = 0; tick(); tick(); cyc_strobe = 0;
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle_inputs();
    cur_a = 0; cur_x = 0; cur_y = 0; cur_sp = 0; cur_ps = 8'h24;
    rst_n = 0;
    #23 rst_n = 1;
    tick();
    chk("R1 reset sp", sp_o, 8'hFD); chk("R9 reset take", take_int, 0);
    chk("R3 reset valid", vec_valid, 0);
    t_cold_fetch();
    t_warm();
    t_priority_restart();
    t_nmi_pipe();
    t_irq_mask();
    t_stall(0, "R7 sprite");
    t_stall(1, "R7 sample");
    t_stall(2, "R7 strobe");
    t_reset_pipe(1'b1);
    t_reset_pipe(1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule